// File: doc/BRIEF.md
# Aligned SPI Transfer Segmenter

This block sits on the host side of an SPI bridge to a memory-mapped target. It takes one transfer request (direction, start address, byte count) and breaks it into a series of bridge commands. Every command is naturally aligned, and the series uses as few commands as the alignment rules allow. A command moves either one 4-byte word or a burst that is a multiple of 8 bytes.

For each segment the block presents a command code, a target address, a segment size and the split of that size into real data bytes and trailing zero padding. A valid/ready handshake carries these fields to the serializer. A downstream SPI engine consumes each segment and moves the bytes. The block pulses `done` after the last segment has been taken. It pulses `err` when a request breaks the alignment rules, and in that case it issues no segment.

Top module: `spi_xfer_splitter`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `seg_valid`=0, `done`=0, `err`=0.
- R2: When the current address has bits [2:0] equal to 4, or 4 or fewer bytes remain, the segment is a single word of exactly 4 bytes.
- R3: In all other cases the segment is a burst. Its size is the remaining count rounded up to a multiple of 8, limited to BURST_MAX (240 by default).
- R4: The first segment address is the start address. Each later segment address is the previous one plus the previous segment size. The last segment is the one whose size is at least the remaining count.
- R5: Command codes are 2 for a word read, 3 for a word write, 4 for a burst read and 5 for a burst write. Codes 0 and 1 are never issued.
- R6: A request is rejected when address bits [1:0] are nonzero, or when it is a read with length bits [1:0] nonzero. Rejection pulses `err` for one cycle, starting the cycle after acceptance, and no segment is issued.
- R7: `seg_data` equals the smaller of the remaining count and the segment size. `seg_pad` equals the segment size minus `seg_data`.
- R8: While `seg_valid`=1 and `seg_ready`=0, the command, address, size, data and pad outputs stay unchanged.
- R9: `req_ready` is 1 only while idle. A request offered while busy is ignored and does not disturb the segment in progress.
- R10: `done` pulses for one cycle, starting the cycle after the last segment handshake. A zero-length request that passes the alignment checks issues no segment and pulses `done` the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Total byte count |
| seg_valid | output | 1 | Segment fields valid |
| seg_ready | input | 1 | Serializer takes the segment |
| seg_cmd | output | 3 | Bridge command code |
| seg_addr | output | AW | Segment byte address |
| seg_bytes | output | SW | Segment size in bytes |
| seg_data | output | SW | Real data bytes in the segment |
| seg_pad | output | SW | Trailing zero padding bytes |
| done | output | 1 | Request finished pulse |
| err | output | 1 | Request rejected pulse |

## Verification
The assertions take two things for granted. First, the serializer may stall for any number of cycles. Second, request fields are sampled only in the cycle of acceptance, so the checks never look at `req_*` while the block is busy. The stimulus drives inputs on the falling edge and holds every request until it sees `req_ready`. It stalls `seg_ready` on some segments and offers a stray request mid-transfer to test that the block ignores it. Lengths are kept well below the LW range, so the remaining count never wraps.

// File: rtl/spi_xfer_splitter.sv
module spi_xfer_splitter #(
  parameter int AW           = 32,
  parameter int LW           = 16,
  parameter int BURST_MAX    = 240,
  parameter int CMD_RD_WORD  = 2,
  parameter int CMD_RD_BURST = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [AW-1:0]                       req_addr,
  input  logic [LW-1:0]                       req_len,
  output logic                                seg_valid,
  input  logic                                seg_ready,
  output logic [2:0]                          seg_cmd,
  output logic [AW-1:0]                       seg_addr,
  output logic [$clog2(BURST_MAX+1)-1:0]      seg_bytes,
  output logic [$clog2(BURST_MAX+1)-1:0]      seg_data,
  output logic [$clog2(BURST_MAX+1)-1:0]      seg_pad,
  output logic                                done,
  output logic                                err
);
  localparam int SW = $clog2(BURST_MAX + 1);

  logic          busy, is_wr, done_q, err_q;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] remain;
  logic [LW:0]   rnd8;
  logic [SW-1:0] burst_len;
  logic          word_seg, last_seg, bad_req, take_req, take_seg;

  assign word_seg  = cur_addr[2] | (remain <= LW'(4));
  assign rnd8      = ({1'b0, remain} + (LW+1)'(7)) & ~((LW+1)'(7));
  assign burst_len = (rnd8 > (LW+1)'(BURST_MAX)) ? SW'(BURST_MAX) : rnd8[SW-1:0];
  assign seg_bytes = word_seg ? SW'(4) : burst_len;
  assign seg_data  = (remain < LW'(seg_bytes)) ? remain[SW-1:0] : seg_bytes;
  assign seg_pad   = seg_bytes - seg_data;
  assign last_seg  = remain <= LW'(seg_bytes);
  assign seg_cmd   = 3'(word_seg ? CMD_RD_WORD : CMD_RD_BURST) + {2'b00, is_wr};
  assign seg_addr  = cur_addr;
  assign seg_valid = busy;
  assign req_ready = ~busy;
  assign done      = done_q;
  assign err       = err_q;

  assign bad_req  = (req_addr[1:0] != 2'b00) | (~req_write & (req_len[1:0] != 2'b00));
  assign take_req = req_valid & ~busy;
  assign take_seg = busy & seg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_wr    <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (take_req) begin
        if (bad_req) begin
          err_q <= 1'b1;
        end else if (req_len == '0) begin
          done_q <= 1'b1;
        end else begin
          busy     <= 1'b1;
          is_wr    <= req_write;
          cur_addr <= req_addr;
          remain   <= req_len;
        end
      end else if (take_seg) begin
        if (last_seg) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur_addr <= cur_addr + AW'(seg_bytes);
          remain   <= remain - LW'(seg_bytes);
        end
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $past(!rst_n) |-> (req_ready && !done && !err)); // R1
  AST_SEG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_addr[1:0] == 2'b00 && (seg_bytes == SW'(4) || seg_addr[2:0] == 3'b000))); // R2
  AST_BURST_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_bytes != SW'(4)) |-> (seg_bytes[2:0] == 3'b000 && seg_bytes <= SW'(BURST_MAX))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && !done_q && seg_pad == '0 && remain != LW'(seg_bytes))
      |=> (seg_valid && seg_addr == $past(seg_addr) + AW'($past(seg_bytes)))); // R4
  AST_NO_HALFWORD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_cmd >= 3'd2 && seg_cmd <= 3'd5)); // R5
  AST_ERR_NO_SEG: assert property (@(posedge clk) disable iff (!rst_n) err |-> !seg_valid); // R6
  AST_PAD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_data + seg_pad == seg_bytes && seg_data != '0)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_bytes)
                                   && $stable(seg_cmd) && $stable(seg_data))); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !seg_valid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
endmodule

// File: tb/tb_spi_xfer_splitter.sv
module tb_spi_xfer_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, seg_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_ready, seg_valid, done, err;
  logic [2:0]  seg_cmd;
  logic [31:0] seg_addr;
  logic [7:0]  seg_bytes, seg_data, seg_pad;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  spi_xfer_splitter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_cmd(seg_cmd),
    .seg_addr(seg_addr), .seg_bytes(seg_bytes), .seg_data(seg_data),
    .seg_pad(seg_pad), .done(done), .err(err));

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_size(input logic [31:0] a, input int rem);
    int r8;
    if (a[2:0] == 3'd4 || rem <= 4) return 4;
    r8 = ((rem + 7) / 8) * 8;
    return (r8 > 240) ? 240 : r8;
  endfunction

  task automatic offer(input logic wr, input logic [31:0] a, input int len);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_req(input logic wr, input logic [31:0] a, input int len, input int stall);
    logic [31:0] ea = a;
    int rem = len, sz, dat, n = 0;
    offer(wr, a, len);
    while (rem > 0) begin
      sz = exp_size(ea, rem);
      dat = (rem < sz) ? rem : sz;
      chk("R4 seg_valid", seg_valid, 1);
      if (n == 1 && stall > 0) begin
        for (int s = 0; s < stall; s++) @(negedge clk);
        chk("R8 held addr", seg_addr, ea);
        chk("R8 held bytes", seg_bytes, sz);
      end
      chk("R4 addr", seg_addr, ea);
      chk(sz == 4 ? "R2 size" : "R3 size", seg_bytes, sz);
      chk("R5 cmd", seg_cmd, (sz == 4 ? 2 : 4) + (wr ? 1 : 0));
      chk("R7 data", seg_data, dat);
      chk("R7 pad", seg_pad, sz - dat);
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
      ea += sz; rem -= sz; n++;
      if (rem > 0) chk("R10 early done", done, 0);
    end
    chk("R10 done", done, 1);
    chk("R9 idle after", req_ready, 1);
    @(negedge clk);
    chk("R10 one pulse", done, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1);
    chk("R1 valid", seg_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_reject(input logic wr, input logic [31:0] a, input int len);
    offer(wr, a, len);
    chk("R6 err", err, 1);
    chk("R6 no seg", seg_valid, 0);
    @(negedge clk);
    chk("R6 err pulse", err, 0);
    chk("R6 still no seg", seg_valid, 0);
  endtask

  task automatic t_zero;
    offer(1'b1, 32'h100, 0);
    chk("R10 zero done", done, 1);
    chk("R10 zero no seg", seg_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    offer(1'b0, 32'h2000, 16);
    chk("R9 busy not ready", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h9004; req_len = 16'd8;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 addr kept", seg_addr, 32'h2000);
    chk("R9 cmd kept", seg_cmd, 4);
    chk("R9 bytes kept", seg_bytes, 16);
    seg_ready = 1'b1;
    @(negedge clk);
    seg_ready = 1'b0;
    chk("R9 done", done, 1);
    chk("R9 no extra seg", seg_valid, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_req(1'b0, 32'h60030004, 256, 0);
    run_req(1'b1, 32'h60030004, 256, 3);
    run_req(1'b1, 32'h00001000, 13, 0);
    run_req(1'b1, 32'h00001004, 3, 0);
    run_req(1'b0, 32'h00000008, 12, 0);
    run_req(1'b0, 32'h00004000, 600, 2);
    run_req(1'b1, 32'h0000400C, 250, 0);
    t_reject(1'b0, 32'h00000002, 8);
    t_reject(1'b0, 32'h00000000, 6);
    t_reject(1'b1, 32'h00000001, 8);
    t_zero();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule